// File: doc/BRIEF.md
# BT.656 Timing-Code Extractor and Sample Demultiplexer

This block sits at the input of a video encoder running in slave mode. It receives one byte per clock of an interleaved 4:2:2 component stream: 27 MHz byte rate, 13.5 Mpps luma. It finds the four-byte timing codes embedded in the stream and checks each one with its protection bits. From the codes it recovers the field, vertical-blanking and horizontal-blanking flags. It also labels each active byte as a Cb, Y or Cr sample.

The sample phase restarts at every accepted code, so the byte after a start-of-line code is always taken as Cb. Pixels are marked valid only between a start-of-line code that has vertical blanking clear and the next accepted code. The four code bytes are never marked valid. A lock flag reports that a start-of-line code and an end-of-line code have been seen on the same line. The lock flag drops when no accepted code arrives within a programmable number of clocks. When the encoder is set to generate its own timing, the block ignores the stream.

Top module: `vid_trs_demux`

## Requirements
- R1: While reset is held, and at the first edge after reset is released, all outputs are 0. `smp_comp` reads 0 (Cb).
- R2: A timing code is the bytes FF, 00, 00, XY. XY bit 7 must be 1, bit 6 is the field F, bit 5 is vertical blanking V, and bit 4 is H (1 = end of line, 0 = start of line). On the clock edge that samples an accepted XY byte, `fld`, `vblank` and `hblank` load F, V and H. At no other time do these three outputs change.
- R3: Protection bits XY[3:0] must equal {V^H, F^H, F^V, F^V^H}. A code whose protection bits do not match is ignored: the flags, the sample phase, the pixel window and the lock state are not affected.
- R4: After any accepted code, the next byte has phase 0. The phase then advances by one per byte in the cycle Cb, Y, Cr, Y. `smp_comp` encodes Cb as 0, Y as 1 and Cr as 2. A byte sampled at edge k appears on `smp_data` and `smp_comp` after edge k+3.
- R5: `pix_vld` is high for exactly those bytes that were sampled after a start-of-line code with V = 0 and before the next accepted code. The four bytes of any accepted code are never valid.
- R6: A start-of-line code with V = 1 opens no pixel window, so no byte after it is valid.
- R7: `locked` rises on the edge that samples an end-of-line code, provided that an accepted start-of-line code with the same F and V came earlier and no timeout came between them.
- R8: `locked` clears on the edge that completes `lock_limit` consecutive clocks with no accepted code.
- R9: While `mode_master` is 1, codes are not accepted and no new byte is marked valid. `locked` is 0 from the next edge on.
- R10: A second start-of-line code in the middle of a line realigns the phase, so the byte after it is again labelled Cb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_master | input | 1 | 1 = encoder makes its own timing; block idle |
| din | input | DW | Interleaved component byte stream |
| lock_limit | input | CW | Clocks without a code before lock is lost |
| smp_data | output | DW | Delayed sample byte |
| smp_comp | output | 2 | Component of `smp_data`: 0 Cb, 1 Y, 2 Cr |
| pix_vld | output | 1 | `smp_data` is an active pixel |
| fld | output | 1 | Field flag from the last accepted code |
| vblank | output | 1 | Vertical blanking flag from the last accepted code |
| hblank | output | 1 | H flag from the last accepted code |
| locked | output | 1 | Start and end codes seen on one line; no timeout since |

## Verification
A wrong sample phase shows up three edges after the offending byte: Cb and Cr swap on `smp_comp`, or a Y is mislabelled. A missed or false code detection changes the flags on the very next edge. It also leaves the four code bytes marked valid, or cuts a run of valid pixels short, three edges later. A wrong timeout count moves the falling edge of `locked` by exactly the size of the error. Comparing the outputs against a behavioural model on every clock therefore catches each of these faults within four cycles of its cause.

// File: rtl/vid_trs_pkg.sv
package vid_trs_pkg;

   typedef enum logic [1:0] {
      COMP_CB = 2'd0,
      COMP_Y  = 2'd1,
      COMP_CR = 2'd2
   } comp_e;

   // protection nibble expected for a given F, V, H
   function automatic logic [3:0] trs_prot(input logic f, input logic v, input logic h);
      return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

   function automatic comp_e phase_to_comp(input logic [1:0] ph);
      case (ph)
         2'd0:    return COMP_CB;
         2'd2:    return COMP_CR;
         default: return COMP_Y;
      endcase
   endfunction

endpackage

// File: rtl/trs_detect.sv
module trs_detect
   import vid_trs_pkg::*;
#(
   parameter int DW         = 8,
   parameter bit PROT_CHECK = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [DW-1:0] din,
   output logic          hit,
   output logic          f,
   output logic          v,
   output logic          h
);

   localparam int PRE = 3;

   logic [DW-1:0] hist [PRE];
   logic          pre_ok;
   logic          prot_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < PRE; i++) hist[i] <= '0;
      end else begin
         hist[0] <= din;
         for (int i = 1; i < PRE; i++) hist[i] <= hist[i-1];
      end
   end

   assign pre_ok = (hist[2] == '1) && (hist[1] == '0) && (hist[0] == '0);
   assign f = din[DW-2];
   assign v = din[DW-3];
   assign h = din[DW-4];

   if (PROT_CHECK) begin : g_prot
      assign prot_ok = (din[DW-5 -: 4] == trs_prot(f, v, h));
   end else begin : g_noprot
      assign prot_ok = 1'b1;
   end

   assign hit = en && pre_ok && din[DW-1] && prot_ok;

   // R2
   preamble_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ($past(din, 1) == '0) && ($past(din, 2) == '0) && ($past(din, 3) == '1));

endmodule

// File: rtl/sample_demux.sv
module sample_demux
   import vid_trs_pkg::*;
#(
   parameter int DW     = 8,
   parameter int STAGES = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          hit,
   input  logic          open_win,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout,
   output comp_e         comp,
   output logic          vld
);

   logic          active;
   logic [1:0]    phase;
   logic [DW-1:0] sd [STAGES];
   logic          sv [STAGES];
   comp_e         sc [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         phase  <= 2'd0;
      end else begin
         phase <= hit ? 2'd0 : phase + 2'd1;
         if (!en)      active <= 1'b0;
         else if (hit) active <= open_win;
      end
   end

   // bytes travel with a valid tag; a code hit clears the tags of its preamble
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) begin
            sd[i] <= '0;
            sv[i] <= 1'b0;
            sc[i] <= COMP_CB;
         end
         dout <= '0;
         vld  <= 1'b0;
         comp <= COMP_CB;
      end else begin
         sd[0] <= din;
         sv[0] <= active && en && !hit;
         sc[0] <= phase_to_comp(phase);
         for (int i = 1; i < STAGES; i++) begin
            sd[i] <= sd[i-1];
            sv[i] <= sv[i-1] && !hit;
            sc[i] <= sc[i-1];
         end
         dout <= sd[STAGES-1];
         vld  <= sv[STAGES-1] && !hit;
         comp <= sc[STAGES-1];
      end
   end

   // R4
   cb_then_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && $past(vld) && ($past(comp) == COMP_CB)) |-> (comp == COMP_Y));

   // R4
   cr_after_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && $past(vld) && ($past(comp) == COMP_CR)) |-> (comp == COMP_Y));

endmodule

// File: rtl/lock_track.sv
module lock_track #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          hit,
   input  logic          f,
   input  logic          v,
   input  logic          h,
   input  logic [CW-1:0] limit,
   output logic          locked
);

   logic [CW-1:0] gap;
   logic          seen;
   logic [1:0]    seen_fv;
   logic          expire;

   assign expire = ({1'b0, gap} + {{CW{1'b0}}, 1'b1}) >= {1'b0, limit};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap     <= '0;
         seen    <= 1'b0;
         seen_fv <= 2'b00;
         locked  <= 1'b0;
      end else begin
         if (hit)              gap <= '0;
         else if (gap != '1)   gap <= gap + 1'b1;

         if (!en) begin
            locked <= 1'b0;
            seen   <= 1'b0;
         end else if (hit) begin
            if (!h) begin
               seen    <= 1'b1;
               seen_fv <= {f, v};
            end else begin
               if (seen && (seen_fv == {f, v})) locked <= 1'b1;
               seen <= 1'b0;
            end
         end else if (expire) begin
            locked <= 1'b0;
            seen   <= 1'b0;
         end
      end
   end

   // R9
   master_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !locked);

   // R7
   lock_on_eav_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> ($past(hit) && $past(h)));

endmodule

// File: rtl/vid_trs_demux.sv
module vid_trs_demux
   import vid_trs_pkg::*;
#(
   parameter int DW         = 8,
   parameter int CW         = 16,
   parameter bit PROT_CHECK = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_master,
   input  logic [DW-1:0] din,
   input  logic [CW-1:0] lock_limit,
   output logic [DW-1:0] smp_data,
   output logic [1:0]    smp_comp,
   output logic          pix_vld,
   output logic          fld,
   output logic          vblank,
   output logic          hblank,
   output logic          locked
);

   localparam int CODE_LEN = 4;
   localparam int STAGES   = CODE_LEN - 1;

   initial begin
      assert (DW >= 8) else $error("DW must be at least 8");
      assert (CW >= 2) else $error("CW must be at least 2");
   end

   logic  en;
   logic  hit;
   logic  xf, xv, xh;
   comp_e comp_q;

   assign en = !mode_master;

   trs_detect #(.DW(DW), .PROT_CHECK(PROT_CHECK)) u_det (
      .clk(clk), .rst_n(rst_n), .en(en), .din(din),
      .hit(hit), .f(xf), .v(xv), .h(xh)
   );

   sample_demux #(.DW(DW), .STAGES(STAGES)) u_dmx (
      .clk(clk), .rst_n(rst_n), .en(en), .hit(hit),
      .open_win(!xh && !xv), .din(din),
      .dout(smp_data), .comp(comp_q), .vld(pix_vld)
   );

   lock_track #(.CW(CW)) u_lock (
      .clk(clk), .rst_n(rst_n), .en(en), .hit(hit),
      .f(xf), .v(xv), .h(xh), .limit(lock_limit), .locked(locked)
   );

   assign smp_comp = comp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fld    <= 1'b0;
         vblank <= 1'b0;
         hblank <= 1'b0;
      end else if (hit) begin
         fld    <= xf;
         vblank <= xv;
         hblank <= xh;
      end
   end

   // R5
   no_pixel_in_vblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_vld |-> !vblank);

   // R2
   flags_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (hblank == $past(xh)) && (vblank == $past(xv)) && (fld == $past(xf)));

   // R9
   master_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_master |=> $stable({fld, vblank, hblank}));

endmodule

// File: tb/tb_vid_trs_demux.sv
module tb_vid_trs_demux;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_master = 1'b0;
   logic [7:0] din = 8'h10;
   logic [15:0] lock_limit = 16'd200;
   logic [7:0] smp_data;
   logic [1:0] smp_comp;
   logic       pix_vld, fld, vblank, hblank, locked;

   int checks = 0;
   int errors = 0;
   bit chk_en = 1'b0;
   bit done = 1'b0;
   string cur_req = "R1";
   int vld_seen = 0;

   always #10 clk = ~clk;

   vid_trs_demux dut (
      .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .din(din),
      .lock_limit(lock_limit), .smp_data(smp_data), .smp_comp(smp_comp),
      .pix_vld(pix_vld), .fld(fld), .vblank(vblank), .hblank(hblank), .locked(locked)
   );

   // behavioural reference model
   typedef struct { logic [7:0] d; bit v; int c; } tag_t;
   logic [7:0] hist[$];
   tag_t pipe[$];
   int m_ph; bit m_act;
   logic [7:0] m_data; int m_comp; bit m_vld;
   bit m_f, m_v, m_h, m_lock, m_seen; bit [1:0] m_fv; int m_gap;

   function automatic logic [3:0] pbits(bit f, bit v, bit h);
      return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

   function automatic int comp_of(int ph);
      return (ph == 0) ? 0 : (ph == 2) ? 2 : 1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         hist = {8'h00, 8'h00, 8'h00};
         pipe.delete();
         for (int i = 0; i < 3; i++) pipe.push_back('{d: 8'h00, v: 1'b0, c: 0});
         m_ph = 0; m_act = 0; m_data = 0; m_comp = 0; m_vld = 0;
         m_f = 0; m_v = 0; m_h = 0; m_lock = 0; m_seen = 0; m_fv = 0; m_gap = 0;
      end else begin
         bit en, hit, xf, xv, xh, expire;
         tag_t e;
         en = !mode_master;
         xf = din[6]; xv = din[5]; xh = din[4];
         hit = en && hist[2] == 8'hFF && hist[1] == 8'h00 && hist[0] == 8'h00 &&
               din[7] && (din[3:0] == pbits(xf, xv, xh));
         e = pipe[2];
         m_data = e.d; m_comp = e.c; m_vld = e.v && !hit;
         void'(pipe.pop_back());
         if (hit) foreach (pipe[i]) pipe[i].v = 1'b0;
         pipe.push_front('{d: din, v: m_act && en && !hit, c: comp_of(m_ph)});
         m_ph = hit ? 0 : (m_ph + 1) % 4;
         if (!en) m_act = 0; else if (hit) m_act = !xh && !xv;
         if (hit) begin m_f = xf; m_v = xv; m_h = xh; end
         expire = (m_gap + 1) >= lock_limit;
         if (!en) begin m_lock = 0; m_seen = 0; end
         else if (hit) begin
            if (!xh) begin m_seen = 1; m_fv = {xf, xv}; end
            else begin if (m_seen && m_fv == {xf, xv}) m_lock = 1; m_seen = 0; end
         end else if (expire) begin m_lock = 0; m_seen = 0; end
         if (hit) m_gap = 0; else if (m_gap < 65535) m_gap++;
         hist.push_front(din); void'(hist.pop_back());
      end
   end

   task automatic chk(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (chk_en) begin
         chk({cur_req, " flags"}, {fld, vblank, hblank}, {m_f, m_v, m_h});
         chk({cur_req, " pix_vld"}, pix_vld, m_vld);
         chk({cur_req, " locked"}, locked, m_lock);
         if (m_vld) begin
            chk({cur_req, " data"}, smp_data, m_data);
            chk({cur_req, " comp"}, smp_comp, m_comp);
         end
         if (pix_vld) vld_seen++;
      end
   end

   task automatic put(logic [7:0] b);
      @(negedge clk);
      din = b;
   endtask

   task automatic code(bit f, bit v, bit h, bit corrupt = 1'b0);
      put(8'hFF); put(8'h00); put(8'h00);
      put({1'b1, f, v, h, pbits(f, v, h) ^ (corrupt ? 4'b0100 : 4'b0000)});
   endtask

   task automatic pixels(int n, int seed);
      for (int i = 0; i < n; i++) put(8'h10 + 8'((seed + i * 7) % 200));
   endtask

   task automatic blank(int n);
      for (int i = 0; i < n; i++) put(i[0] ? 8'h10 : 8'h80);
   endtask

   task automatic line(bit f, bit v, int n, int seed);
      code(f, v, 1'b0); pixels(n, seed); code(f, v, 1'b1); blank(8);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      cur_req = "R1";
      chk("R1 reset outputs", {smp_data, smp_comp, pix_vld, fld, vblank, hblank, locked}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 first edge outputs", {smp_data, smp_comp, pix_vld, fld, vblank, hblank, locked}, 0);
      chk_en = 1'b1;
      blank(6);

      cur_req = "R2"; line(0, 0, 16, 1);
      cur_req = "R4"; line(0, 0, 21, 5);
      cur_req = "R7"; line(1, 0, 12, 9);
      repeat (2) @(negedge clk);
      chk("R7 lock after paired codes", locked, 1);

      cur_req = "R5"; vld_seen = 0; line(1, 0, 10, 3); blank(4);
      chk("R5 valid pixel count", vld_seen, 10);

      cur_req = "R6"; vld_seen = 0; line(1, 1, 12, 4); blank(4);
      chk("R6 no pixels in vertical blanking", vld_seen, 0);

      cur_req = "R3";
      code(0, 0, 1'b0, 1'b1); pixels(6, 2); blank(4);
      chk("R3 bad code ignored hblank", hblank, 1);
      line(0, 0, 8, 6);

      cur_req = "R10";
      code(0, 0, 1'b0); pixels(5, 11); code(0, 0, 1'b0); pixels(9, 12);
      code(0, 0, 1'b1); blank(6);

      cur_req = "R8";
      lock_limit = 16'd20;
      line(0, 0, 8, 13);
      blank(12);
      chk("R8 lock held inside limit", locked, 1);
      blank(14);
      chk("R8 lock lost after limit", locked, 0);
      line(0, 0, 8, 14);
      lock_limit = 16'd200;

      cur_req = "R9";
      mode_master = 1'b1;
      line(0, 0, 8, 15);
      chk("R9 master unlocks", locked, 0);
      vld_seen = 0; line(0, 0, 8, 16);
      chk("R9 master no pixels", vld_seen, 0);
      mode_master = 1'b0;
      blank(4);
      cur_req = "R2"; line(1, 0, 8, 17); blank(6);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule